// File: doc/BRIEF.md
# Slew-Rate Calibration Sequencer

This block runs the high-speed transmitter slew-rate calibration without software help. On a start pulse it powers the ring oscillator, lets it settle for a fixed number of cycles, switches on the free-running clock, programs the measurement window and starts an external frequency meter. It then checks the meter's valid flag at a fixed poll interval, with a bounded number of polls. Once valid is seen, or the polls run out, it captures the count and shuts the meter and the clock down in a fixed order.

From the captured count a sequential divider forms the quotient of the constant `REF_MHZ * COEF * WINDOW` over the count. That quotient, rounded to the nearest multiple of `ROUND_DIV` and saturated to the code width, becomes the slew code. A zero count selects a fixed fallback code. The code is written to the transmitter field with a one-cycle strobe. After that the oscillator is switched off and a done pulse marks the end. When a forced slew value is in use, the `forceEn` input makes a start pulse skip the whole sequence.

Top module: `slew_cal_seq`

## Requirements
- R1: After reset, `oscEn`, `frclkEn`, `meterEn`, `slewWe`, `busy` and `done` are 0, and `slewCode` and `meterWindow` are 0.
- R2: A start pulse with `forceEn` high raises no enable, no `slewWe` and no `busy`. It gives one `done` pulse in the next cycle and leaves `slewCode` unchanged.
- R3: A start pulse with `forceEn` low raises `oscEn` and `busy` on the next edge. `frclkEn` rises exactly `SETTLE_CYC` cycles after `oscEn`, and `meterWindow` is loaded with `WINDOW` at the same edge. `meterEn` rises one cycle after that.
- R4: `meterValid` is sampled once every `POLL_CYC` cycles while the meter runs. When the k-th sample finds it high, `meterEn` has been high for exactly k × `POLL_CYC` cycles when it falls.
- R5: If `POLL_MAX` samples all find `meterValid` low, `meterEn` falls after `POLL_MAX` × `POLL_CYC` cycles. The value on `meterCount` is captured anyway and the sequence goes on without error.
- R6: `meterEn` falls at the capture edge, and `frclkEn` falls exactly one cycle later. `frclkEn` is never high without `oscEn`, and `meterEn` is never high without `frclkEn`.
- R7: For a non-zero count C, the code is round-half-up(floor(`REF_MHZ`×`COEF`×`WINDOW` / C) / `ROUND_DIV`).
- R8: A code above 2^`CODE_W`−1 (7 for the default 3-bit field) is saturated to that maximum.
- R9: A captured count of zero gives the code `DEFAULT_CODE` (3 by default).
- R10: `slewWe` pulses for one cycle with the new code on `slewCode`. `oscEn` falls one cycle after that pulse, together with a one-cycle `done` pulse. `busy` is high from the rise of `oscEn` until `done`.
- R11: A start pulse while `busy` is high is ignored: no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to calibrate |
| forceEn | input | 1 | A forced slew value is in use; skip the sequence |
| meterValid | input | 1 | Frequency meter result ready |
| meterCount | input | CNT_W | Frequency meter result |
| oscEn | output | 1 | Ring oscillator enable |
| frclkEn | output | 1 | Free-running clock enable |
| meterEn | output | 1 | Frequency meter enable |
| meterWindow | output | WIN_W | Measurement window in reference cycles |
| slewCode | output | CODE_W | Transmitter slew control field |
| slewWe | output | 1 | Write strobe for `slewCode` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (one cycle) |

## Verification
The bench keeps the default reference of 26 MHz, the coefficient of 17, the window of 1024 and the 3-bit field. The codes it expects are therefore those of the real formula, including both sides of a rounding boundary (counts 301 and 302) and saturation (counts 50 and 1). It shrinks the timing to `SETTLE_CYC`=4, `POLL_CYC`=6 and `POLL_MAX`=3. A run that finds valid on a later poll and a run that times out then take only tens of cycles, and the exact enable widths stay easy to predict.

// File: rtl/slew_cal_pkg.sv
package slew_cal_pkg;

  // Strobes from the sequencer to the datapath, one cycle each.
  typedef struct packed {
    logic oscSet;
    logic oscClr;
    logic clkSet;
    logic clkClr;
    logic mtrSet;
    logic mtrClr;
    logic capture;
    logic divStart;
    logic codeWrite;
    logic finish;
  } seqStrobe_t;

endpackage

// File: rtl/slew_cal_div.sv
// Restoring divider, one quotient bit per cycle.
module slew_cal_div #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int BW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W-1:0]  quo;
  logic [BW-1:0] bitCnt;
  logic          run;
  logic [W:0]    remShift;

  assign remShift = {rem[W-1:0], quo[W-1]};
  assign quotient = quo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem    <= '0;
      quo    <= '0;
      bitCnt <= '0;
      run    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem    <= '0;
        quo    <= dividend;
        bitCnt <= '0;
        run    <= 1'b1;
      end else if (run) begin
        if (remShift >= {1'b0, divisor}) begin
          rem <= remShift - {1'b0, divisor};
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= remShift;
          quo <= {quo[W-2:0], 1'b0};
        end
        if (bitCnt == BW'(W - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/slew_cal_ctrl.sv
module slew_cal_ctrl
  import slew_cal_pkg::*;
#(
  parameter int SETTLE_CYC = 200,
  parameter int POLL_CYC   = 2000,
  parameter int POLL_MAX   = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       forceEn,
  input  logic       meterValid,
  input  logic       capZero,
  input  logic       divDone,
  output seqStrobe_t stb,
  output logic       busy
);
  localparam int LONGEST = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam int PW      = $clog2(POLL_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_ARM, S_POLL, S_CLKOFF, S_DIV, S_WRITE, S_OSCOFF
  } state_t;

  state_t        state, nextState;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pollNum;
  logic          pollTick;

  assign pollTick = (state == S_POLL) && (cnt == CW'(POLL_CYC - 1));
  assign busy     = (state != S_IDLE);

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        if (forceEn) stb.finish = 1'b1;
        else begin
          stb.oscSet = 1'b1;
          nextState  = S_SETTLE;
        end
      end
      S_SETTLE: if (cnt == CW'(SETTLE_CYC - 1)) begin
        stb.clkSet = 1'b1;
        nextState  = S_ARM;
      end
      S_ARM: begin
        stb.mtrSet = 1'b1;
        nextState  = S_POLL;
      end
      S_POLL: if (pollTick && (meterValid || pollNum == PW'(POLL_MAX - 1))) begin
        stb.capture = 1'b1;
        stb.mtrClr  = 1'b1;
        nextState   = S_CLKOFF;
      end
      S_CLKOFF: begin
        stb.clkClr = 1'b1;
        if (capZero) nextState = S_WRITE;
        else begin
          stb.divStart = 1'b1;
          nextState    = S_DIV;
        end
      end
      S_DIV: if (divDone) nextState = S_WRITE;
      S_WRITE: begin
        stb.codeWrite = 1'b1;
        nextState     = S_OSCOFF;
      end
      S_OSCOFF: begin
        stb.oscClr = 1'b1;
        stb.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      pollNum <= '0;
    end else begin
      state <= nextState;
      if (state != nextState) begin
        cnt <= '0;
        if (nextState == S_POLL) pollNum <= '0;
      end else if (pollTick) begin
        cnt     <= '0;
        pollNum <= pollNum + 1'b1;
      end else if (state == S_SETTLE || state == S_POLL) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/slew_cal_dp.sv
module slew_cal_dp
  import slew_cal_pkg::*;
#(
  parameter int REF_MHZ      = 26,
  parameter int COEF         = 17,
  parameter int WINDOW       = 1024,
  parameter int ROUND_DIV    = 1000,
  parameter int CODE_W       = 3,
  parameter int DEFAULT_CODE = 3,
  parameter int CNT_W        = 24,
  parameter int WIN_W        = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [CNT_W-1:0]  meterCount,
  output logic              capZero,
  output logic              divDone,
  output logic              oscEn,
  output logic              frclkEn,
  output logic              meterEn,
  output logic [WIN_W-1:0]  meterWindow,
  output logic [CODE_W-1:0] slewCode,
  output logic              slewWe,
  output logic              done
);
  localparam int NUM      = REF_MHZ * COEF * WINDOW;
  localparam int NUM_W    = $clog2(NUM + 1);
  localparam int DW       = (NUM_W > CNT_W) ? NUM_W : CNT_W;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int HALF     = ROUND_DIV / 2;

  logic [CNT_W-1:0]    capCount;
  logic [DW-1:0]       quot;
  logic [CODE_MAX-1:0] geStep;
  logic [CODE_W-1:0]   calcCode;

  assign capZero = (capCount == '0);

  slew_cal_div #(.W(DW)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .start    (stb.divStart),
    .dividend (DW'(NUM)),
    .divisor  (DW'(capCount)),
    .quotient (quot),
    .done     (divDone)
  );

  // Thermometer of rounding thresholds; its population count is the
  // rounded code, and it cannot exceed CODE_MAX, which saturates.
  for (genvar k = 1; k <= CODE_MAX; k++) begin : gStep
    assign geStep[k-1] = (64'(quot) >= 64'(k * ROUND_DIV - HALF));
  end

  always_comb begin
    calcCode = '0;
    for (int i = 0; i < CODE_MAX; i++) calcCode = calcCode + CODE_W'(geStep[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oscEn       <= 1'b0;
      frclkEn     <= 1'b0;
      meterEn     <= 1'b0;
      meterWindow <= '0;
      capCount    <= '0;
      slewCode    <= '0;
      slewWe      <= 1'b0;
      done        <= 1'b0;
    end else begin
      if (stb.oscSet) oscEn <= 1'b1;
      else if (stb.oscClr) oscEn <= 1'b0;
      if (stb.clkSet) begin
        frclkEn     <= 1'b1;
        meterWindow <= WIN_W'(WINDOW);
      end else if (stb.clkClr) begin
        frclkEn <= 1'b0;
      end
      if (stb.mtrSet) meterEn <= 1'b1;
      else if (stb.mtrClr) meterEn <= 1'b0;
      if (stb.capture) capCount <= meterCount;
      if (stb.codeWrite) slewCode <= capZero ? CODE_W'(DEFAULT_CODE) : calcCode;
      slewWe <= stb.codeWrite;
      done   <= stb.finish;
    end
  end
endmodule

// File: rtl/slew_cal_seq.sv
module slew_cal_seq
  import slew_cal_pkg::*;
#(
  parameter int REF_MHZ      = 26,
  parameter int COEF         = 17,
  parameter int WINDOW       = 1024,
  parameter int ROUND_DIV    = 1000,
  parameter int CODE_W       = 3,
  parameter int DEFAULT_CODE = 3,
  parameter int CNT_W        = 24,
  parameter int WIN_W        = 24,
  parameter int SETTLE_CYC   = 200,
  parameter int POLL_CYC     = 2000,
  parameter int POLL_MAX     = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              forceEn,
  input  logic              meterValid,
  input  logic [CNT_W-1:0]  meterCount,
  output logic              oscEn,
  output logic              frclkEn,
  output logic              meterEn,
  output logic [WIN_W-1:0]  meterWindow,
  output logic [CODE_W-1:0] slewCode,
  output logic              slewWe,
  output logic              busy,
  output logic              done
);
  seqStrobe_t stb;
  logic       capZero;
  logic       divDone;

  slew_cal_ctrl #(
    .SETTLE_CYC (SETTLE_CYC),
    .POLL_CYC   (POLL_CYC),
    .POLL_MAX   (POLL_MAX)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .forceEn    (forceEn),
    .meterValid (meterValid),
    .capZero    (capZero),
    .divDone    (divDone),
    .stb        (stb),
    .busy       (busy)
  );

  slew_cal_dp #(
    .REF_MHZ      (REF_MHZ),
    .COEF         (COEF),
    .WINDOW       (WINDOW),
    .ROUND_DIV    (ROUND_DIV),
    .CODE_W       (CODE_W),
    .DEFAULT_CODE (DEFAULT_CODE),
    .CNT_W        (CNT_W),
    .WIN_W        (WIN_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .meterCount  (meterCount),
    .capZero     (capZero),
    .divDone     (divDone),
    .oscEn       (oscEn),
    .frclkEn     (frclkEn),
    .meterEn     (meterEn),
    .meterWindow (meterWindow),
    .slewCode    (slewCode),
    .slewWe      (slewWe),
    .done        (done)
  );
endmodule

// File: rtl/slew_cal_seq_chk.sv
module slew_cal_seq_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              forceEn,
  input logic              oscEn,
  input logic              frclkEn,
  input logic              meterEn,
  input logic [CODE_W-1:0] slewCode,
  input logic              slewWe,
  input logic              busy,
  input logic              done
);
  AST_CLK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rstN)
    frclkEn |-> oscEn);                                               // R6
  AST_METER_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rstN)
    meterEn |-> frclkEn);                                             // R6
  AST_CLK_OFF_AFTER_METER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frclkEn) |-> !$past(meterEn));                              // R6
  AST_OSC_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    oscEn |-> busy);                                                  // R10
  AST_WRITE_WITH_OSC_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    slewWe |-> (oscEn && !frclkEn && !meterEn));                      // R10
  AST_DONE_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !oscEn && !frclkEn));                          // R10
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !slewWe |-> $stable(slewCode));                                   // R2
  AST_FORCE_SKIPS: assert property (@(posedge clk) disable iff (!rstN)
    (start && forceEn && !busy) |=> (done && !busy && !oscEn));       // R2
endmodule

bind slew_cal_seq slew_cal_seq_chk #(.CODE_W(CODE_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .forceEn  (forceEn),
  .oscEn    (oscEn),
  .frclkEn  (frclkEn),
  .meterEn  (meterEn),
  .slewCode (slewCode),
  .slewWe   (slewWe),
  .busy     (busy),
  .done     (done)
);

// File: tb/tb_slew_cal_seq.sv
`timescale 1ns/1ps
module tb_slew_cal_seq;
  localparam int REF_MHZ   = 26;
  localparam int COEF      = 17;
  localparam int WINDOW    = 1024;
  localparam int ROUND_DIV = 1000;
  localparam int CODE_W    = 3;
  localparam int DEF_CODE  = 3;
  localparam int CNT_W     = 24;
  localparam int WIN_W     = 24;
  localparam int SETTLE    = 4;
  localparam int POLLC     = 6;
  localparam int POLLN     = 3;
  localparam int NUM       = REF_MHZ * COEF * WINDOW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic forceEn = 1'b0;
  logic meterValid;
  logic [CNT_W-1:0] meterCount;
  logic oscEn, frclkEn, meterEn, slewWe, busy, done;
  logic [WIN_W-1:0] meterWindow;
  logic [CODE_W-1:0] slewCode;

  always #2.5 clk = ~clk;

  slew_cal_seq #(
    .REF_MHZ(REF_MHZ), .COEF(COEF), .WINDOW(WINDOW), .ROUND_DIV(ROUND_DIV),
    .CODE_W(CODE_W), .DEFAULT_CODE(DEF_CODE), .CNT_W(CNT_W), .WIN_W(WIN_W),
    .SETTLE_CYC(SETTLE), .POLL_CYC(POLLC), .POLL_MAX(POLLN)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .forceEn(forceEn),
    .meterValid(meterValid), .meterCount(meterCount),
    .oscEn(oscEn), .frclkEn(frclkEn), .meterEn(meterEn),
    .meterWindow(meterWindow), .slewCode(slewCode), .slewWe(slewWe),
    .busy(busy), .done(done)
  );

  // Frequency meter model: valid once meterEn has been high for validDelay edges.
  int tbCount = 0;
  int validDelay = 0;
  int mCnt = 0;
  always @(posedge clk) mCnt <= meterEn ? mCnt + 1 : 0;
  assign meterValid = meterEn && (mCnt >= validDelay);
  assign meterCount = meterValid ? CNT_W'(tbCount) : '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    kind;
    int    data;
    string tag;
  } ev_t;
  ev_t expQ[$];

  task automatic pushExp(input int k, input int d, input string t);
    ev_t e;
    e.kind = k; e.data = d; e.tag = t;
    expQ.push_back(e);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic observe(input int k, input int d);
    ev_t e;
    if (expQ.size() == 0) begin
      checks++;
      errors++;
      $display("FAIL R11: unexpected event kind %0d data %0d, expected none", k, d);
    end else begin
      e = expQ.pop_front();
      check(e.kind == k && e.data == d, e.tag, k * 1000000 + d, e.kind * 1000000 + e.data);
    end
  endtask

  // Monitor: turns port transitions into events (kind, data).
  logic pBusy = 0, pOsc = 0, pClk = 0, pMtr = 0;
  int tOsc = 0, tMtrOn = 0, tMtrOff = 0, tWe = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (busy && !pBusy) observe(0, 0);
      if (oscEn && !pOsc) begin observe(1, 0); tOsc = cyc; end
      if (frclkEn && !pClk) observe(2, cyc - tOsc);
      if (meterEn && !pMtr) begin observe(3, int'(meterWindow)); tMtrOn = cyc; end
      if (!meterEn && pMtr) begin observe(4, cyc - tMtrOn); tMtrOff = cyc; end
      if (!frclkEn && pClk) observe(5, cyc - tMtrOff);
      if (slewWe) begin observe(6, int'(slewCode)); tWe = cyc; end
      if (!oscEn && pOsc) observe(7, cyc - tWe);
      if (done) observe(8, {busy, oscEn});
    end
    pBusy = busy; pOsc = oscEn; pClk = frclkEn; pMtr = meterEn;
  end

  function automatic int expCode(input int count);
    int q, c;
    if (count == 0) return DEF_CODE;
    q = NUM / count;
    c = (q + ROUND_DIV / 2) / ROUND_DIV;
    if (c > (1 << CODE_W) - 1) c = (1 << CODE_W) - 1;
    return c;
  endfunction

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (expQ.size() > 0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (expQ.size() > 0) begin
      checks++;
      errors++;
      $display("FAIL %s: watchdog, %0d events missing, expected 0", expQ[0].tag, expQ.size());
      expQ.delete();
    end
    repeat (3) @(negedge clk);
  endtask

  // Driver: pushes the full expected event list of one run, then starts it.
  task automatic runCal(input int count, input int delay, input string codeTag,
                        input string widthTag, input bit extraStart);
    int k = 1;
    int capCount;
    while (k < POLLN && (k * POLLC - 1) < delay) k++;
    capCount = ((k * POLLC - 1) >= delay) ? count : 0;
    pushExp(0, 0, "R10");
    pushExp(1, 0, "R3");
    pushExp(2, SETTLE, "R3");
    pushExp(3, WINDOW, "R3");
    pushExp(4, k * POLLC, widthTag);
    pushExp(5, 1, "R6");
    pushExp(6, expCode(capCount), codeTag);
    pushExp(7, 1, "R10");
    pushExp(8, 0, "R10");
    tbCount = count;
    validDelay = delay;
    pulseStart();
    if (extraStart) begin
      repeat (3) @(negedge clk);
      pulseStart();
      repeat (8) @(negedge clk);
      pulseStart();
    end
    drain();
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finishSim();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(oscEn == 0 && frclkEn == 0 && meterEn == 0, "R1 enables", {oscEn, frclkEn, meterEn}, 0);
    check(slewWe == 0 && busy == 0 && done == 0, "R1 status", {slewWe, busy, done}, 0);
    check(slewCode == 0 && meterWindow == 0, "R1 code/window", int'(slewCode) + int'(meterWindow), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runCal(113, 0, "R7", "R4", 0);   // code 4, valid on first poll
    runCal(301, 7, "R7", "R4", 0);   // quotient 1503 rounds up to 2, second poll
    runCal(302, 0, "R7", "R4", 0);   // quotient 1498 rounds down to 1
    runCal(50, 0, "R8", "R4", 0);    // 9052 saturates to 7
    runCal(1, 0, "R8", "R4", 0);     // very large quotient saturates to 7
    runCal(0, 0, "R9", "R4", 0);     // valid zero count gives default 3
    runCal(120, 1000, "R9", "R5", 0);// timeout, captured zero, default 3
    runCal(100, 0, "R7", "R4", 1);   // R11: extra starts while busy, code 5
    repeat (20) @(negedge clk);
    check(busy == 0 && expQ.size() == 0, "R11 idle after ignored starts", int'(busy), 0);

    // R2 forced value: only a done pulse, code unchanged (still 5)
    forceEn = 1'b1;
    pushExp(8, 0, "R2");
    pulseStart();
    drain();
    check(slewCode == 3'd5, "R2 code retained", int'(slewCode), 5);
    check(oscEn == 0 && busy == 0, "R2 no activity", {oscEn, busy}, 0);
    forceEn = 1'b0;

    runCal(226, 0, "R7", "R4", 0);   // 2002 rounds to 2, after forced request
    finishSim();
  end
endmodule